// File: doc/BRIEF.md
# Secure Multi-CPU Interrupt Router

This block gathers a set of interrupt inputs and delivers each one to several processors. Every input has a routing slot for each processor. The slot selects the line type (IRQ or FIQ), a priority level, and a security bit. A rising edge on an input latches a pending flag. For every processor and line type, the router raises the line while a pending input is routed to it with a nonzero priority. Alongside the line it reports the index of the most urgent such input.

Software reaches the block through a simple register port. Each write carries a secure qualifier bit. Writable registers can be updated in three ways: plain write, set-only alias at offset +4, and clear-only alias at offset +8. The security rules work as follows:
- A slot whose security bit is set can only be changed by a secure write.
- A pending flag of a secured input is hidden from, and cannot be cleared by, non-secure accesses.
- A lock bit in the control register protects the gating and soft-reset bits.

Top module: `irq_router`

## Requirements
- R1: After reset, every register reads 0 and all IRQ/FIQ lines and winner indices are 0.
- R2: A 0-to-1 transition on `src_i[i]` sets pending bit i on the next clock. When this happens in the same cycle as a clear write to that bit, the bit still ends up set.
- R3: Routing register i sits at 0x20 + 0x10*i and holds 4-bit slots, one per processor. Processor n uses bits [4n+3:4n]: bit 0 is security, bit 1 is type (1 = FIQ), and bits [3:2] are priority. Sub-offset 0 writes the register, +4 ORs the data in, and +8 clears the bits that are 1 in the data. Any other sub-offset has no effect.
- R4: A non-secure write leaves unchanged every slot whose security bit is currently 1. All other slots of the same register are updated.
- R5: The pending register reads at 0x10 and clears through 0x18. An input counts as secured when any of its slots has its security bit set. A non-secure read shows 0 for secured inputs, and a non-secure clear does not affect them.
- R6: The control register sits at 0x0, with aliases at 0x4 and 0x8. Bit 7 is gate, bit 6 is soft reset and bit 5 is lock; all other bits read 0. While lock is 1, non-secure writes do not change gate or soft reset.
- R7: While gate is 1, writes to the pending and routing registers are ignored. Control writes still apply.
- R8: Writing 1 to soft reset holds that bit at 1 for exactly 4 cycles. During those cycles the pending and routing registers are forced to 0, and afterwards the bit clears itself.
- R9: The IRQ (FIQ) line of processor n is 1 exactly when some pending input has slot n with type IRQ (FIQ) and a priority other than 0.
- R10: The winner index is the pending, matching input with the highest priority value. Ties go to the lowest index. The index is 0 when the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC (32) | Interrupt inputs, rising-edge detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_secure | input | 1 | Access is secure |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | N_CPU (4) | IRQ line per processor |
| fiq_o | output | N_CPU (4) | FIQ line per processor |
| irq_id_o | output | N_CPU*5 (20) | Winning input index per processor, IRQ |
| fiq_id_o | output | N_CPU*5 (20) | Winning input index per processor, FIQ |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- An edge landing in the same cycle as a clear of that bit. A design that lets the clear win drops an interrupt.
- A non-secure write that spans both protected and unprotected slots. An all-or-nothing protection check corrupts the protected slot or refuses the open ones.
- Secured pending bits under non-secure reads and clears. A leaky design exposes them or lets them be cleared.
- Two inputs tied at the same priority. A comparison with the wrong direction or strictness reports the higher index.
- The soft-reset length. A counter that is off by one gives a pulse of three or five cycles.
- Locked gating, for which a design that ignores the qualifier lets non-secure software freeze the block.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // Register update mode chosen by the low address nibble
    typedef enum logic [1:0] {
        UPD_WRITE = 2'd0,
        UPD_SET   = 2'd1,
        UPD_CLEAR = 2'd2,
        UPD_NONE  = 2'd3
    } upd_e;

    // Slot priority levels
    typedef enum logic [1:0] {
        LVL_OFF  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_NMI  = 2'd3
    } lvl_e;

    localparam int SLOT_W    = 4;
    localparam int SLOT_SEC  = 0;
    localparam int SLOT_TYPE = 1;
    localparam int SLOT_LVL  = 2;

    function automatic upd_e decode_upd(input logic [3:0] sub);
        case (sub)
            4'h0:    return UPD_WRITE;
            4'h4:    return UPD_SET;
            4'h8:    return UPD_CLEAR;
            default: return UPD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int N_SRC       = 32,
    parameter int N_CPU       = 4,
    parameter int ADDR_W      = 12,
    parameter int SRST_CYCLES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       src_i,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [31:0]            reg_wdata,
    input  logic                   reg_secure,
    output logic [31:0]            reg_rdata,
    output logic [N_SRC-1:0]       status_o,
    output logic [N_SRC*N_CPU*SLOT_W-1:0] route_o,
    output logic                   gate_o,
    output logic                   lock_o,
    output logic                   srst_o,
    output logic [N_SRC-1:0]       prev_o
);
    localparam int RW    = N_CPU * SLOT_W;
    localparam int BLK_W = ADDR_W - 4;
    localparam int IDX_W = $clog2(N_SRC);
    localparam int CNT_W = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;

    typedef struct packed {
        logic                       gate;
        logic                       srst;
        logic                       lock;
        logic [CNT_W-1:0]           cnt;
        logic [N_SRC-1:0]           status;
        logic [N_SRC-1:0]           prev;
        logic [N_SRC-1:0][RW-1:0]   route;
    } state_t;

    state_t q, d;

    logic [BLK_W-1:0] blk;
    upd_e             upd;
    logic             hit_ctrl, hit_stat, hit_route;
    logic [IDX_W-1:0] ridx;
    logic [N_SRC-1:0] secured;
    logic [N_SRC-1:0] rise;

    assign blk       = reg_addr[ADDR_W-1:4];
    assign upd       = decode_upd(reg_addr[3:0]);
    assign hit_ctrl  = (blk == '0);
    assign hit_stat  = (blk == BLK_W'(1));
    assign hit_route = (blk >= BLK_W'(2)) && (blk < BLK_W'(2 + N_SRC));
    assign ridx      = IDX_W'(blk - BLK_W'(2));
    assign rise      = src_i & ~q.prev;

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            secured[i] = 1'b0;
            for (int c = 0; c < N_CPU; c++) begin
                secured[i] = secured[i] | q.route[i][c*SLOT_W + SLOT_SEC];
            end
        end
    end

    always_comb begin
        logic [7:0]    ctrl_old, ctrl_new;
        logic [RW-1:0] r_old, r_new;
        d      = q;
        d.prev = src_i;

        // control register
        ctrl_old = {q.gate, q.srst, q.lock, 5'b0};
        case (upd)
            UPD_WRITE: ctrl_new = reg_wdata[7:0];
            UPD_SET:   ctrl_new = ctrl_old | reg_wdata[7:0];
            UPD_CLEAR: ctrl_new = ctrl_old & ~reg_wdata[7:0];
            default:   ctrl_new = ctrl_old;
        endcase
        if (reg_wr && hit_ctrl && upd != UPD_NONE) begin
            d.lock = ctrl_new[5];
            if (!q.lock || reg_secure) begin
                d.gate = ctrl_new[7];
                if (!q.srst) begin
                    d.srst = ctrl_new[6];
                end
            end
        end

        // pending clear
        if (reg_wr && hit_stat && upd == UPD_CLEAR && !q.gate) begin
            d.status = q.status &
                       ~(reg_wdata[N_SRC-1:0] & (reg_secure ? {N_SRC{1'b1}} : ~secured));
        end

        // routing update with per-slot protection
        r_old = q.route[ridx];
        case (upd)
            UPD_WRITE: r_new = reg_wdata[RW-1:0];
            UPD_SET:   r_new = r_old | reg_wdata[RW-1:0];
            UPD_CLEAR: r_new = r_old & ~reg_wdata[RW-1:0];
            default:   r_new = r_old;
        endcase
        if (reg_wr && hit_route && !q.gate) begin
            for (int c = 0; c < N_CPU; c++) begin
                if (reg_secure || !r_old[c*SLOT_W + SLOT_SEC]) begin
                    d.route[ridx][c*SLOT_W +: SLOT_W] = r_new[c*SLOT_W +: SLOT_W];
                end
            end
        end

        // edge capture wins over a clear in the same cycle
        d.status = d.status | rise;

        // soft reset sequence
        if (q.srst) begin
            d.status = '0;
            d.route  = '0;
            if (q.cnt == CNT_W'(SRST_CYCLES - 1)) begin
                d.srst = 1'b0;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl) begin
            reg_rdata[7:5] = {q.gate, q.srst, q.lock};
        end else if (hit_stat) begin
            reg_rdata[N_SRC-1:0] = q.status & (reg_secure ? {N_SRC{1'b1}} : ~secured);
        end else if (hit_route) begin
            reg_rdata[RW-1:0] = q.route[ridx];
        end
    end

    assign status_o = q.status;
    assign route_o  = q.route;
    assign gate_o   = q.gate;
    assign lock_o   = q.lock;
    assign srst_o   = q.srst;
    assign prev_o   = q.prev;

endmodule

// File: rtl/irq_router_arb.sv
module irq_router_arb #(
    parameter int N_SRC = 32,
    parameter int ID_W  = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]      pend_i,
    input  logic [N_SRC-1:0][1:0] lvl_i,
    input  logic [N_SRC-1:0]      sel_i,
    output logic                  req_o,
    output logic [ID_W-1:0]       id_o
);
    always_comb begin
        logic [1:0] best;
        best = 2'd0;
        id_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend_i[i] && sel_i[i] && (lvl_i[i] > best)) begin
                best = lvl_i[i];
                id_o = ID_W'(i);
            end
        end
        req_o = (best != 2'd0);
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int N_CPU  = 4,
    parameter int ADDR_W = 12,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      src_i,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic                  reg_secure,
    output logic [31:0]           reg_rdata,
    output logic [N_CPU-1:0]      irq_o,
    output logic [N_CPU-1:0]      fiq_o,
    output logic [N_CPU*ID_W-1:0] irq_id_o,
    output logic [N_CPU*ID_W-1:0] fiq_id_o
);
    localparam int RW = N_CPU * SLOT_W;

    logic [N_SRC-1:0]       status_w;
    logic [N_SRC*RW-1:0]    route_w;
    logic                   gate_w, lock_w, srst_w;
    logic [N_SRC-1:0]       prev_w;

    irq_router_regs #(
        .N_SRC(N_SRC), .N_CPU(N_CPU), .ADDR_W(ADDR_W), .SRST_CYCLES(4)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_secure(reg_secure), .reg_rdata(reg_rdata),
        .status_o(status_w), .route_o(route_w), .gate_o(gate_w),
        .lock_o(lock_w), .srst_o(srst_w), .prev_o(prev_w)
    );

    logic [N_CPU-1:0][N_SRC-1:0][1:0] lvl_v;
    logic [N_CPU-1:0][N_SRC-1:0]      fiq_sel;

    always_comb begin
        for (int c = 0; c < N_CPU; c++) begin
            for (int i = 0; i < N_SRC; i++) begin
                lvl_v[c][i]   = route_w[i*RW + c*SLOT_W + SLOT_LVL +: 2];
                fiq_sel[c][i] = route_w[i*RW + c*SLOT_W + SLOT_TYPE];
            end
        end
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        irq_router_arb #(.N_SRC(N_SRC), .ID_W(ID_W)) u_irq (
            .pend_i(status_w), .lvl_i(lvl_v[c]), .sel_i(~fiq_sel[c]),
            .req_o(irq_o[c]), .id_o(irq_id_o[c*ID_W +: ID_W])
        );
        irq_router_arb #(.N_SRC(N_SRC), .ID_W(ID_W)) u_fiq (
            .pend_i(status_w), .lvl_i(lvl_v[c]), .sel_i(fiq_sel[c]),
            .req_o(fiq_o[c]), .id_o(fiq_id_o[c*ID_W +: ID_W])
        );
    end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int N_SRC  = 32,
    parameter int N_CPU  = 4,
    parameter int ADDR_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_SRC-1:0]      src_i,
    input logic                  reg_wr,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  reg_secure,
    input logic [31:0]           reg_rdata,
    input logic [N_CPU-1:0]      irq_o,
    input logic [N_CPU-1:0]      fiq_o,
    input logic [N_SRC-1:0]      status_q,
    input logic [N_SRC*N_CPU*4-1:0] route_q,
    input logic                  gate_q,
    input logic                  lock_q,
    input logic                  srst_q,
    input logic [N_SRC-1:0]      prev_q
);
    localparam int RW = N_CPU * 4;

    logic [N_SRC-1:0] sec_mask;
    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            sec_mask[i] = 1'b0;
            for (int c = 0; c < N_CPU; c++) begin
                sec_mask[i] = sec_mask[i] | route_q[i*RW + c*4];
            end
        end
    end

    logic [3:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (srst_q) run_q <= run_q + 4'd1;
        else             run_q <= '0;
    end

    logic blk_ctrl, blk_stat, is_clr;
    assign blk_ctrl = (reg_addr[ADDR_W-1:4] == '0);
    assign blk_stat = (reg_addr[ADDR_W-1:4] == (ADDR_W-4)'(1));
    assign is_clr   = (reg_addr[3:0] == 4'h8);

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_q |=> ((status_q & $past(src_i & ~prev_q)) == $past(src_i & ~prev_q)));

    assert_ns_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_stat && !reg_secure) |-> ((reg_rdata[N_SRC-1:0] & sec_mask) == '0));

    assert_ns_clear_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && blk_stat && is_clr && !reg_secure && !srst_q) |=>
        ((status_q & $past(status_q & sec_mask)) == $past(status_q & sec_mask)));

    assert_lock_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !reg_secure && reg_wr && blk_ctrl) |=> $stable(gate_q));

    assert_gate_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && !srst_q && reg_wr && !blk_ctrl) |=> $stable(route_q));

    assert_srst_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |-> (run_q < 4'd4));

    assert_srst_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_q) |-> (run_q == 4'd4));

    assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> (irq_o == '0 && fiq_o == '0));

endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_secure(reg_secure), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .status_q(status_w), .route_q(route_w),
    .gate_q(gate_w), .lock_q(lock_w), .srst_q(srst_w), .prev_q(prev_w)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
    localparam int NS = 32;
    localparam int NC = 4;
    localparam int AW = 12;
    localparam int IW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   src = '0;
    logic            wr = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic            sec = 1'b0;
    logic [31:0]     rdata;
    logic [NC-1:0]   irq_o, fiq_o;
    logic [NC*IW-1:0] irq_id, fiq_id;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_secure(sec), .reg_rdata(rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .irq_id_o(irq_id), .fiq_id_o(fiq_id)
    );

    // reference state
    logic [NS-1:0] m_status, m_prev;
    logic [15:0]   m_route [NS];
    logic          m_gate, m_lock, m_srst;
    int            m_cnt;

    task automatic model_reset();
        m_status = '0; m_prev = '0; m_gate = 0; m_lock = 0; m_srst = 0; m_cnt = 0;
        for (int i = 0; i < NS; i++) m_route[i] = '0;
    endtask

    function automatic logic [NS-1:0] m_secured();
        logic [NS-1:0] s;
        for (int i = 0; i < NS; i++)
            s[i] = m_route[i][0] | m_route[i][4] | m_route[i][8] | m_route[i][12];
        return s;
    endfunction

    function automatic logic [31:0] apply(int mode, logic [31:0] old, logic [31:0] dv);
        if (mode == 0) return dv;
        if (mode == 1) return old | dv;
        if (mode == 2) return old & ~dv;
        return old;
    endfunction

    task automatic model_step();
        logic [NS-1:0] secm, rise;
        logic [7:0] cn;
        logic [15:0] ro, rn;
        int blk, mode, idx;
        logic n_gate, n_srst, n_lock;
        secm = m_secured();
        rise = src & ~m_prev;
        blk  = int'(addr[AW-1:4]);
        mode = (addr[3:0] == 4'h0) ? 0 : (addr[3:0] == 4'h4) ? 1 : (addr[3:0] == 4'h8) ? 2 : 3;
        n_gate = m_gate; n_srst = m_srst; n_lock = m_lock;
        if (wr && blk == 0 && mode != 3) begin
            cn = 8'(apply(mode, {24'b0, m_gate, m_srst, m_lock, 5'b0}, wdata));
            n_lock = cn[5];
            if (!m_lock || sec) begin
                n_gate = cn[7];
                if (!m_srst) n_srst = cn[6];
            end
        end
        if (wr && blk == 1 && mode == 2 && !m_gate)
            m_status = m_status & ~(wdata & (sec ? 32'hFFFF_FFFF : ~secm));
        if (wr && blk >= 2 && blk < 2 + NS && !m_gate && mode != 3) begin
            idx = blk - 2;
            ro = m_route[idx];
            rn = 16'(apply(mode, {16'b0, ro}, wdata));
            for (int c = 0; c < NC; c++)
                if (sec || !ro[c*4]) m_route[idx][c*4 +: 4] = rn[c*4 +: 4];
        end
        m_status = m_status | rise;
        if (m_srst) begin
            m_status = '0;
            for (int i = 0; i < NS; i++) m_route[i] = '0;
            if (m_cnt == 3) begin n_srst = 0; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end
        m_gate = n_gate; m_srst = n_srst; m_lock = n_lock;
        m_prev = src;
    endtask

    function automatic logic [31:0] model_read(logic [AW-1:0] a, logic s);
        int blk;
        blk = int'(a[AW-1:4]);
        if (blk == 0) return {24'b0, m_gate, m_srst, m_lock, 5'b0};
        if (blk == 1) return m_status & (s ? 32'hFFFF_FFFF : ~m_secured());
        if (blk >= 2 && blk < 2 + NS) return {16'b0, m_route[blk-2]};
        return '0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R9 R10 expected lines
    task automatic check_outputs();
        logic [NC-1:0] ei, ef;
        logic [NC*IW-1:0] eii, efi;
        logic [1:0] bi, bf;
        logic [3:0] sl;
        ei = '0; ef = '0; eii = '0; efi = '0;
        for (int c = 0; c < NC; c++) begin
            bi = 0; bf = 0;
            for (int i = 0; i < NS; i++) begin
                sl = m_route[i][c*4 +: 4];
                if (m_status[i] && !sl[1] && sl[3:2] > bi) begin bi = sl[3:2]; eii[c*IW +: IW] = IW'(i); end
                if (m_status[i] &&  sl[1] && sl[3:2] > bf) begin bf = sl[3:2]; efi[c*IW +: IW] = IW'(i); end
            end
            ei[c] = (bi != 0); ef[c] = (bf != 0);
        end
        chk("R9/R10 lines", {16'b0, irq_o, fiq_o, irq_id, fiq_id}, {16'b0, ei, ef, eii, efi});
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic wr_reg(logic [AW-1:0] a, logic [31:0] dv, logic s);
        wr = 1; addr = a; wdata = dv; sec = s;
        tick();
        wr = 0;
    endtask

    task automatic rd_chk(string tag, logic [AW-1:0] a, logic s);
        addr = a; sec = s; #1;
        chk(tag, {32'b0, rdata}, {32'b0, model_read(a, s)});
    endtask

    task automatic rd_val(string tag, logic [AW-1:0] a, logic s, logic [31:0] exp);
        addr = a; sec = s; #1;
        chk(tag, {32'b0, rdata}, {32'b0, exp});
    endtask

    function automatic logic [AW-1:0] raddr(int i, int sub);
        return AW'(32'h20 + 32'h10 * i + sub);
    endfunction

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_val("R1 ctrl", 12'h000, 1, 0);
        rd_val("R1 status", 12'h010, 1, 0);
        rd_val("R1 route", raddr(5, 0), 1, 0);
        chk("R1 lines", {56'b0, irq_o, fiq_o}, 64'b0);
        tick();

        // R3 aliases
        wr_reg(raddr(3, 0), 32'h1234, 1);
        rd_val("R3 write", raddr(3, 0), 1, 32'h1234);
        wr_reg(raddr(3, 4), 32'h0808, 1);
        rd_val("R3 set alias", raddr(3, 0), 1, 32'h1A3C);
        wr_reg(raddr(3, 8), 32'h0030, 1);
        rd_val("R3 clear alias", raddr(3, 0), 1, 32'h1A0C);
        wr_reg(raddr(3, 12), 32'hFFFF, 1);
        rd_val("R3 bad offset", raddr(3, 0), 1, 32'h1A0C);

        // R4 per-slot protection: slot3 secured
        wr_reg(raddr(3, 0), 32'hFFFF, 0);
        rd_val("R4 partial", raddr(3, 0), 1, 32'h1FFF);
        wr_reg(raddr(3, 0), 32'h0000, 1);
        rd_val("R4 secure write", raddr(3, 0), 1, 32'h0000);

        // R10 tie and level
        wr_reg(raddr(4, 0), 32'h0004, 1);
        wr_reg(raddr(9, 0), 32'h0008, 1);
        wr_reg(raddr(2, 0), 32'h0008, 1);
        src[4] = 1; src[9] = 1; src[2] = 1;
        tick();
        chk("R10 tie lowest", {59'b0, irq_o[0], irq_id[4:0]}, {59'b0, 1'b1, 5'd2});
        wr_reg(raddr(4, 0), 32'h000C, 1);
        chk("R10 nmi wins", {59'b0, irq_o[0], irq_id[4:0]}, {59'b0, 1'b1, 5'd4});

        // R2 set beats same-cycle clear
        src[7] = 0; tick();
        src[7] = 1;
        wr_reg(12'h018, 32'h0000_0080, 1);
        rd_val("R2 set wins", 12'h010, 1, 32'h0000_0294);
        wr_reg(12'h018, 32'hFFFF_FFFF, 1);
        rd_val("R2 cleared", 12'h010, 1, 0);
        chk("R9 idle", {56'b0, irq_o, fiq_o}, 64'b0);

        // R5 secured pending
        wr_reg(raddr(10, 0), 32'h00B0, 1);
        src[10] = 1; tick();
        rd_val("R5 ns hidden", 12'h010, 0, 0);
        rd_val("R5 s visible", 12'h010, 1, 32'h0000_0400);
        chk("R9 fiq cpu1", {58'b0, fiq_o[1], fiq_id[9:5]}, {58'b0, 1'b1, 5'd10});
        wr_reg(12'h018, 32'h0000_0400, 0);
        rd_val("R5 ns clear ignored", 12'h010, 1, 32'h0000_0400);
        wr_reg(12'h018, 32'h0000_0400, 1);
        rd_val("R5 s clear", 12'h010, 1, 0);

        // R6 lock
        wr_reg(12'h000, 32'h20, 1);
        wr_reg(12'h004, 32'h80, 0);
        rd_val("R6 locked gate", 12'h000, 0, 32'h20);
        wr_reg(12'h004, 32'h80, 1);
        rd_val("R6 secure gate", 12'h000, 0, 32'hA0);

        // R7 gate blocks
        wr_reg(raddr(6, 0), 32'h5555, 1);
        rd_val("R7 route frozen", raddr(6, 0), 1, 0);
        src[11] = 1; tick();
        wr_reg(12'h018, 32'h0000_0800, 1);
        rd_val("R7 clear frozen", 12'h010, 1, 32'h0000_0800);
        wr_reg(12'h008, 32'hA0, 1);
        rd_val("R6 unlock", 12'h000, 1, 0);

        // R8 soft reset length and effect
        wr_reg(raddr(6, 0), 32'h5554, 1);
        wr_reg(12'h004, 32'h40, 0);
        for (int k = 0; k < 4; k++) begin
            rd_val("R8 held", 12'h000, 1, 32'h40);
            tick();
        end
        rd_val("R8 self clear", 12'h000, 1, 0);
        rd_val("R8 route zero", raddr(6, 0), 1, 0);
        rd_val("R8 status zero", 12'h010, 1, 0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 100);
            src = src ^ ($urandom & $urandom & $urandom);
            if (r < 40) begin
                wr = 1; addr = raddr(int'($urandom % NS), int'($urandom % 4) * 4);
                wdata = $urandom & 32'hFFFF; sec = 1'($urandom);
            end else if (r < 55) begin
                wr = 1; addr = 12'h018; wdata = $urandom; sec = 1'($urandom);
            end else if (r < 59) begin
                wr = 1; addr = AW'((($urandom % 3)) * 4);
                wdata = ($urandom & 32'hA0) | ((($urandom % 8) == 0) ? 32'h40 : 32'h0);
                sec = 1'($urandom);
            end else if (r < 62) begin
                wr = 1; addr = AW'($urandom); wdata = $urandom; sec = 1'($urandom);
            end else begin
                wr = 0;
            end
            tick();
            wr = 0;
            if (n % 2 == 0) rd_chk("R3/R5 read", AW'(($urandom % (NS + 2)) * 16), 1'($urandom));
            else            rd_chk("R5 status", 12'h010, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule